// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces the line and frame timing for a raster display. One counter steps through the clock positions of a line and another steps through the lines of a frame. Both are decoded into an active-low line sync, an active-low frame sync, a flag that marks the visible lines, and a flag that marks the horizontal window in which pixel bytes may be fetched. An interrupt request rises once the visible area of the frame has been scanned.

The generator is clocked by the pixel clock. With the default parameters a line is 1024 clocks and a frame is 312 lines. A mode input chooses between a tall picture of 256 visible lines and a short one of 250 lines. The current position and the chosen picture height are also brought out, so that neighbouring logic can line up with the raster. Every flag comes from a register and changes on the same edge as the position counters.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst_n` is low, the block is at line 0, position 0. In that state `hsync_n` and `vsync_n` are 0, and `disp_active`, `fetch_en` and `vsync_irq` are 0.
- R2: `hpos` rises by one on each clock. From LINE_CLKS-1 (1023) it goes to 0, and at that step `line_num` rises by one. From FRAME_LINES-1 (311) `line_num` goes to 0.
- R3: `hsync_n` is 0 for positions 0 to HSYNC_END-1 (63) and 1 for the rest of every line.
- R4: `vsync_n` is 0 from line 0 position 0 up to line 2 position 511, and 1 from line 2 position 512 to the end of the frame.
- R5: `disp_active` is 1 on lines ACT_FIRST (28) through ACT_FIRST+H-1. H is 256 when `short_mode` is 0 and 250 when it is 1, and `disp_height` shows H.
- R6: `fetch_en` is 1 only on active lines, at positions FETCH_FIRST (256) through FETCH_LAST (895) inclusive.
- R7: `vsync_irq` becomes 1 at line ACT_FIRST+256 (284), position 0, whatever the mode. It holds until line 0, position 0 of the next frame, where it returns to 0.
- R8: When `irq_clr` is 1 at a clock edge, `vsync_irq` is 0 after that edge. The exception is an edge that moves the raster to the set point of R7: there the set wins and `vsync_irq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| short_mode | input | 1 | 1 selects the short picture height |
| irq_clr | input | 1 | Clears the frame interrupt |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| disp_active | output | 1 | Current line is visible |
| fetch_en | output | 1 | Pixel fetch window |
| vsync_irq | output | 1 | Frame interrupt request |
| line_num | output | VW | Current line |
| hpos | output | HW | Current clock position in the line |
| disp_height | output | VW | Visible line count for the chosen mode |

## Verification
The bench runs the generator with small line and frame sizes, so that several whole frames fit in the run. Every output is compared, on every clock, against positions the bench computes from the number of clocks since reset. A tall frame and a short frame test the edges of the visible window in each mode. Two cases test the interrupt clear: a pulse in the middle of the interrupt window, and a pulse on the edge that sets the interrupt. A reset in the middle of a frame confirms that the raster restarts at its origin.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef struct packed {
    logic hsync_n;
    logic vsync_n;
    logic active;
    logic fetch;
  } rtg_flags_t;

  localparam rtg_flags_t FLAGS_RST = '{hsync_n: 1'b0, vsync_n: 1'b0, active: 1'b0, fetch: 1'b0};
endpackage

// File: rtl/rtg_counters.sv
module rtg_counters #(
  parameter int LINE_CLKS   = 1024,
  parameter int FRAME_LINES = 312,
  localparam int HW = $clog2(LINE_CLKS),
  localparam int VW = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hpos_q,
  output logic [VW-1:0] line_q,
  output logic [HW-1:0] hpos_d,
  output logic [VW-1:0] line_d
);
  localparam logic [HW-1:0] H_LAST = HW'(LINE_CLKS - 1);
  localparam logic [VW-1:0] V_LAST = VW'(FRAME_LINES - 1);

  logic line_en;

  always_comb begin
    line_en = (hpos_q == H_LAST);
    hpos_d  = line_en ? '0 : hpos_q + 1'b1;
    line_d  = line_q;
    if (line_en) begin
      line_d = (line_q == V_LAST) ? '0 : line_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpos_q <= '0;
      line_q <= '0;
    end else begin
      hpos_q <= hpos_d;
      if (line_en) begin
        line_q <= line_d;
      end
    end
  end

  // R2: position steps by one inside a line
  p_hpos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos_q != H_LAST) |=> (hpos_q == $past(hpos_q) + 1'b1));
  // R2: frame wraps to line 0
  p_line_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos_q == H_LAST && line_q == V_LAST) |=> (line_q == '0 && hpos_q == '0));
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
  import rtg_pkg::*;
#(
  parameter int HW          = 10,
  parameter int VW          = 9,
  parameter int HSYNC_END   = 64,
  parameter int VS_LINE     = 2,
  parameter int VS_POS      = 512,
  parameter int ACT_FIRST   = 28,
  parameter int TALL        = 256,
  parameter int SHORT       = 250,
  parameter int FETCH_FIRST = 256,
  parameter int FETCH_LAST  = 895
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          short_mode,
  input  logic [HW-1:0] hpos_d,
  input  logic [VW-1:0] line_d,
  input  logic [HW-1:0] hpos_q,
  input  logic [VW-1:0] line_q,
  output rtg_flags_t    flags_q,
  output logic [VW-1:0] height
);
  localparam logic [HW-1:0] HS_END  = HW'(HSYNC_END);
  localparam logic [VW-1:0] VSL     = VW'(VS_LINE);
  localparam logic [HW-1:0] VSP     = HW'(VS_POS);
  localparam logic [VW-1:0] A_FIRST = VW'(ACT_FIRST);
  localparam logic [VW-1:0] A_END_T = VW'(ACT_FIRST + TALL);
  localparam logic [VW-1:0] A_END_S = VW'(ACT_FIRST + SHORT);
  localparam logic [HW-1:0] F_FIRST = HW'(FETCH_FIRST);
  localparam logic [HW-1:0] F_LAST  = HW'(FETCH_LAST);

  rtg_flags_t flags_d;
  logic [VW-1:0] act_end;

  always_comb begin
    height  = short_mode ? VW'(SHORT) : VW'(TALL);
    act_end = short_mode ? A_END_S : A_END_T;
    flags_d.hsync_n = (hpos_d >= HS_END);
    flags_d.vsync_n = !((line_d < VSL) || (line_d == VSL && hpos_d < VSP));
    flags_d.active  = (line_d >= A_FIRST) && (line_d < act_end);
    flags_d.fetch   = flags_d.active && (hpos_d >= F_FIRST) && (hpos_d <= F_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= FLAGS_RST;
    else        flags_q <= flags_d;
  end

  // R3: line sync releases exactly at its end position
  p_hsync_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.hsync_n) |-> (hpos_q == HS_END));
  // R4: frame sync releases mid-line on its release line
  p_vsync_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.vsync_n) |-> (line_q == VSL && hpos_q == VSP));
  // R6: fetch only inside the horizontal window
  p_fetch_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.fetch |-> (hpos_q >= F_FIRST && hpos_q <= F_LAST));
  // R5: visible lines begin at the first active line
  p_active_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.active) |-> (line_q == A_FIRST && hpos_q == '0));
endmodule

// File: rtl/rtg_irq.sv
module rtg_irq #(
  parameter int HW       = 10,
  parameter int VW       = 9,
  parameter int IRQ_LINE = 284
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_clr,
  input  logic [HW-1:0] hpos_d,
  input  logic [VW-1:0] line_d,
  input  logic [HW-1:0] hpos_q,
  input  logic [VW-1:0] line_q,
  output logic          irq_q
);
  localparam logic [VW-1:0] IRQ_L = VW'(IRQ_LINE);

  logic set_ev, frame_ev, irq_d;

  always_comb begin
    set_ev   = (line_d == IRQ_L) && (hpos_d == '0);
    frame_ev = (line_d == '0) && (hpos_d == '0);
    if (set_ev)                    irq_d = 1'b1;
    else if (frame_ev || irq_clr)  irq_d = 1'b0;
    else                           irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  // R7: set at the start of the interrupt line
  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q == IRQ_L && hpos_q == '0) |-> irq_q);
  // R7: cleared at frame origin
  p_irq_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q == '0 && hpos_q == '0) |-> !irq_q);
  // R8: explicit clear takes effect unless the set point is reached
  p_irq_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> (!irq_q || (line_q == IRQ_L && hpos_q == '0)));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int LINE_CLKS   = 1024,
  parameter int FRAME_LINES = 312,
  parameter int HSYNC_END   = 64,
  parameter int VS_LINE     = 2,
  parameter int VS_POS      = 512,
  parameter int ACT_FIRST   = 28,
  parameter int TALL        = 256,
  parameter int SHORT       = 250,
  parameter int FETCH_FIRST = 256,
  parameter int FETCH_LAST  = 895,
  localparam int HW = $clog2(LINE_CLKS),
  localparam int VW = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          short_mode,
  input  logic          irq_clr,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          disp_active,
  output logic          fetch_en,
  output logic          vsync_irq,
  output logic [VW-1:0] line_num,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] disp_height
);
  localparam int IRQ_LINE = ACT_FIRST + TALL;

  logic [HW-1:0] hpos_d;
  logic [VW-1:0] line_d;
  rtg_flags_t    flags;

  rtg_counters #(.LINE_CLKS(LINE_CLKS), .FRAME_LINES(FRAME_LINES)) cnt_i (
    .clk(clk), .rst_n(rst_n),
    .hpos_q(hpos), .line_q(line_num), .hpos_d(hpos_d), .line_d(line_d)
  );

  rtg_decode #(
    .HW(HW), .VW(VW), .HSYNC_END(HSYNC_END), .VS_LINE(VS_LINE), .VS_POS(VS_POS),
    .ACT_FIRST(ACT_FIRST), .TALL(TALL), .SHORT(SHORT),
    .FETCH_FIRST(FETCH_FIRST), .FETCH_LAST(FETCH_LAST)
  ) dec_i (
    .clk(clk), .rst_n(rst_n), .short_mode(short_mode),
    .hpos_d(hpos_d), .line_d(line_d), .hpos_q(hpos), .line_q(line_num),
    .flags_q(flags), .height(disp_height)
  );

  rtg_irq #(.HW(HW), .VW(VW), .IRQ_LINE(IRQ_LINE)) irq_i (
    .clk(clk), .rst_n(rst_n), .irq_clr(irq_clr),
    .hpos_d(hpos_d), .line_d(line_d), .hpos_q(hpos), .line_q(line_num),
    .irq_q(vsync_irq)
  );

  assign hsync_n     = flags.hsync_n;
  assign vsync_n     = flags.vsync_n;
  assign disp_active = flags.active;
  assign fetch_en    = flags.fetch;
endmodule

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;
  localparam int LC  = 64;
  localparam int FL  = 40;
  localparam int HSE = 4;
  localparam int VSL = 2;
  localparam int VSP = 32;
  localparam int AF  = 4;
  localparam int TAL = 16;
  localparam int SHO = 10;
  localparam int FF  = 16;
  localparam int FLS = 55;
  localparam int IRQL = AF + TAL;
  localparam int HW = $clog2(LC);
  localparam int VW = $clog2(FL);

  logic clk = 1'b0;
  logic rst_n, short_mode, irq_clr;
  logic hsync_n, vsync_n, disp_active, fetch_en, vsync_irq;
  logic [VW-1:0] line_num, disp_height;
  logic [HW-1:0] hpos;

  int total = 0;
  int bad = 0;
  int idx = 0;
  bit exp_irq = 0;

  raster_timing_gen #(
    .LINE_CLKS(LC), .FRAME_LINES(FL), .HSYNC_END(HSE), .VS_LINE(VSL), .VS_POS(VSP),
    .ACT_FIRST(AF), .TALL(TAL), .SHORT(SHO), .FETCH_FIRST(FF), .FETCH_LAST(FLS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .short_mode(short_mode), .irq_clr(irq_clr),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .disp_active(disp_active),
    .fetch_en(fetch_en), .vsync_irq(vsync_irq), .line_num(line_num),
    .hpos(hpos), .disp_height(disp_height)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at line %0d pos %0d: actual=%0d expected=%0d",
               req, idx / LC, idx % LC, act, exp);
    end
  endtask

  task automatic check_all();
    int l, p, h;
    bit act;
    l = idx / LC;
    p = idx % LC;
    h = short_mode ? SHO : TAL;
    act = (l >= AF) && (l < AF + h);
    chk("R2 hpos", int'(hpos), p);
    chk("R2 line", int'(line_num), l);
    chk("R3 hsync_n", int'(hsync_n), int'(p >= HSE));
    chk("R4 vsync_n", int'(vsync_n), int'(!(l < VSL || (l == VSL && p < VSP))));
    chk("R5 active", int'(disp_active), int'(act));
    chk("R5 height", int'(disp_height), h);
    chk("R6 fetch", int'(fetch_en), int'(act && p >= FF && p <= FLS));
    chk("R7 R8 irq", int'(vsync_irq), int'(exp_irq));
  endtask

  // one clock: drive at negedge, model the edge, check at the next negedge
  task automatic step(input bit clr);
    int l, p;
    irq_clr = clr;
    @(posedge clk);
    idx = (idx + 1) % (LC * FL);
    l = idx / LC;
    p = idx % LC;
    if (l == IRQL && p == 0)          exp_irq = 1;
    else if ((l == 0 && p == 0) || clr) exp_irq = 0;
    @(negedge clk);
    irq_clr = 1'b0;
    check_all();
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    idx = 0;
    exp_irq = 0;
    // R1: reset state
    chk("R1 hpos", int'(hpos), 0);
    chk("R1 line", int'(line_num), 0);
    chk("R1 hsync_n", int'(hsync_n), 0);
    chk("R1 vsync_n", int'(vsync_n), 0);
    chk("R1 active", int'(disp_active), 0);
    chk("R1 fetch", int'(fetch_en), 0);
    chk("R1 irq", int'(vsync_irq), 0);
    rst_n = 1'b1;
  endtask

  // full frame in the given mode, including the wrap back to line 0
  task automatic t_frame(input bit mode);
    short_mode = mode;
    for (int i = 0; i < LC * FL; i++) step(1'b0);
  endtask

  // R8: clear coinciding with the set edge, then clear mid-window
  task automatic t_irq_clear();
    short_mode = 1'b0;
    while (idx != IRQL * LC - 1) step(1'b0);
    step(1'b1);
    chk("R8 set wins", int'(vsync_irq), 1);
    for (int i = 0; i < 3 * LC; i++) step(1'b0);
    step(1'b1);
    chk("R8 cleared", int'(vsync_irq), 0);
    while (idx != 0) step(1'b0);
  endtask

  task automatic t_mid_reset();
    for (int i = 0; i < 30 * LC + 7; i++) step(1'b0);
    t_reset();
    for (int i = 0; i < 3 * LC; i++) step(1'b0);
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    short_mode = 1'b0;
    irq_clr = 1'b0;
    t_reset();
    t_frame(1'b0);
    t_frame(1'b1);
    t_irq_clear();
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule